// File: doc/BRIEF.md
# Per-Channel Test-Waveform Replay Buffer

This block sits between the per-channel sample streams of a multichannel flash-ADC front end and the trigger datapath that consumes them. Each channel owns a small pattern memory that a host fills ahead of time through a plain write port, giving a channel index, a sample address and the sample value. Every channel can hold a different pulse shape.

A single playback strobe, common to all channels, arrives asynchronously and is brought into the sample-clock domain through two flip-flops. While the synchronised strobe is high, every channel emits its stored samples from address 0 upward, one per sample clock, instead of its live ADC data. The number of samples replayed equals the number of clocks the strobe is high. A strobe longer than the memory holds the last sample. When the strobe is low, the live ADC samples pass straight through. A one-clock done pulse marks the end of each replay. A host write that lands during a replay is dropped and raises a sticky collision flag.

Top module: `pattern_replay`

## Requirements
- R1: While reset is asserted, outValid, replayActive, replayDone and writeCollision are 0. outValid becomes 1 on the first clock edge after reset is released and stays 1.
- R2: When no replay is in progress, a clock edge with hostWe high stores hostData at address hostAddr of channel hostCh. A later write to the same location replaces the stored value.
- R3: When no replay is in progress, the slice of outData for channel c, bits [c*SAMPLE_W +: SAMPLE_W], equals that channel's liveData slice from one clock earlier.
- R4: strobeIn passes through two synchroniser flops. The clock edge that first captures strobeIn high is edge 1. Replayed data and replayActive=1 appear on outData after clock edge 3, and replayActive tracks strobeIn delayed by three clocks.
- R5: During a replay, each channel outputs its own stored samples at addresses 0, 1, 2, … on consecutive clocks. The number of replayed samples equals the number of clock edges at which strobeIn was sampled high.
- R6: If the strobe stays high for more than DEPTH clocks, the output stays at the sample at address DEPTH-1 for the rest of the replay. The address does not wrap.
- R7: Each new rising edge of the synchronised strobe restarts the replay at address 0, even when the previous replay ended only a few clocks earlier.
- R8: During a replay, the values on liveData have no effect on outData.
- R9: replayDone is high for exactly one clock: the clock in which outData first returns to live data and replayActive falls.
- R10: A host write issued while the synchronised strobe is high leaves the pattern memory unchanged. It also sets writeCollision, which then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| liveData | input | NUM_CH*SAMPLE_W | Live ADC samples, channel c in bits [c*SAMPLE_W +: SAMPLE_W] |
| hostWe | input | 1 | Host write enable |
| hostCh | input | clog2(NUM_CH) | Channel selected for the host write |
| hostAddr | input | clog2(DEPTH) | Sample address for the host write |
| hostData | input | SAMPLE_W | Sample value to store |
| strobeIn | input | 1 | Asynchronous playback strobe, shared by all channels |
| outData | output | NUM_CH*SAMPLE_W | Per-channel output samples, same packing as liveData |
| outValid | output | 1 | Output stream carries data (set after reset) |
| replayActive | output | 1 | outData carries replayed samples |
| replayDone | output | 1 | One-clock pulse at the end of a replay |
| writeCollision | output | 1 | Sticky flag: a host write was dropped during a replay |

## Verification
The bench builds the block with 4 channels, an 8-deep pattern memory and 8-bit samples. With this configuration it can write every location of every channel and compute the expected output of each one from a simple arithmetic pattern. A memory this short also lets the bench use strobes shorter than, equal to and longer than the memory within a few dozen clocks, so saturation at the last address and a restart right after a long replay are both covered. The bench exercises live pass-through over a sweep of input patterns, and it probes a write collision by replaying the location it tried to overwrite.

// File: rtl/pattern_replay_pkg.sv
package pattern_replay_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // host write accepted this clock
    logic replay;  // emit stored samples this clock
  } ctrlStrobes_t;
endpackage

// File: rtl/pattern_replay_ctrl.sv
module pattern_replay_ctrl
  import pattern_replay_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeIn,
  input  logic              hostWe,
  output ctrlStrobes_t      ctrl,
  output logic [ADDR_W-1:0] rdAddrSel,
  output logic              replayActive,
  output logic              replayDone,
  output logic              writeCollision
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic syncQ1, strobeS, strobeD;
  logic [ADDR_W-1:0] rdAddr;
  logic strobeRise;

  assign strobeRise = strobeS & ~strobeD;

  always_comb begin
    rdAddrSel   = strobeRise ? '0 : rdAddr;
    ctrl.wrEn   = hostWe & ~strobeS;
    ctrl.replay = strobeS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ1         <= 1'b0;
      strobeS        <= 1'b0;
      strobeD        <= 1'b0;
      rdAddr         <= '0;
      replayActive   <= 1'b0;
      replayDone     <= 1'b0;
      writeCollision <= 1'b0;
    end else begin
      syncQ1       <= strobeIn;
      strobeS      <= syncQ1;
      strobeD      <= strobeS;
      replayActive <= strobeS;
      replayDone   <= strobeD & ~strobeS;
      if (strobeS) begin
        rdAddr <= (rdAddrSel == LAST_ADDR) ? LAST_ADDR : rdAddrSel + 1'b1;
      end
      if (hostWe && strobeS) begin
        writeCollision <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pattern_replay_dpath.sv
module pattern_replay_dpath
  import pattern_replay_pkg::*;
#(
  parameter int unsigned NUM_CH   = 16,
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned CH_W     = 4,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               ctrl,
  input  logic [CH_W-1:0]            hostCh,
  input  logic [ADDR_W-1:0]          hostAddr,
  input  logic [SAMPLE_W-1:0]        hostData,
  input  logic [ADDR_W-1:0]          rdAddr,
  input  logic [NUM_CH*SAMPLE_W-1:0] liveData,
  output logic [NUM_CH*SAMPLE_W-1:0] outData,
  output logic                       outValid
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= 1'b1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [SAMPLE_W-1:0] patMem [DEPTH];
    logic [SAMPLE_W-1:0] outQ;
    logic [SAMPLE_W-1:0] liveCh;

    assign liveCh = liveData[ch*SAMPLE_W +: SAMPLE_W];

    always_ff @(posedge clk) begin
      if (ctrl.wrEn && (hostCh == CH_W'(ch))) begin
        patMem[hostAddr] <= hostData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            outQ <= '0;
      else if (ctrl.replay) outQ <= patMem[rdAddr];
      else                  outQ <= liveCh;
    end

    assign outData[ch*SAMPLE_W +: SAMPLE_W] = outQ;
  end
endmodule

// File: rtl/pattern_replay.sv
module pattern_replay
  import pattern_replay_pkg::*;
#(
  parameter int unsigned NUM_CH   = 16,
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned SAMPLE_W = 12,
  localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned ADDR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CH*SAMPLE_W-1:0] liveData,
  input  logic                       hostWe,
  input  logic [CH_W-1:0]            hostCh,
  input  logic [ADDR_W-1:0]          hostAddr,
  input  logic [SAMPLE_W-1:0]        hostData,
  input  logic                       strobeIn,
  output logic [NUM_CH*SAMPLE_W-1:0] outData,
  output logic                       outValid,
  output logic                       replayActive,
  output logic                       replayDone,
  output logic                       writeCollision
);
  ctrlStrobes_t      ctrl;
  logic [ADDR_W-1:0] rdAddr;

  pattern_replay_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .strobeIn       (strobeIn),
    .hostWe         (hostWe),
    .ctrl           (ctrl),
    .rdAddrSel      (rdAddr),
    .replayActive   (replayActive),
    .replayDone     (replayDone),
    .writeCollision (writeCollision)
  );

  pattern_replay_dpath #(
    .NUM_CH(NUM_CH), .DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W),
    .CH_W(CH_W), .ADDR_W(ADDR_W)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .hostCh   (hostCh),
    .hostAddr (hostAddr),
    .hostData (hostData),
    .rdAddr   (rdAddr),
    .liveData (liveData),
    .outData  (outData),
    .outValid (outValid)
  );
endmodule

// File: rtl/pattern_replay_chk.sv
module pattern_replay_chk #(
  parameter int unsigned BUS_W = 192
) (
  input logic             clk,
  input logic             rstN,
  input logic             strobeIn,
  input logic [BUS_W-1:0] liveData,
  input logic [BUS_W-1:0] outData,
  input logic             outValid,
  input logic             replayActive,
  input logic             replayDone,
  input logic             writeCollision
);
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sinceRst <= '0;
    else if (sinceRst != 2'd3)  sinceRst <= sinceRst + 1'b1;
  end

  AST_LIVE_PASSTHROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !replayActive) |-> (outData == $past(liveData))); // R3

  AST_ACTIVE_TRACKS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (replayActive == $past(strobeIn, 3))); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    replayDone |=> !replayDone); // R9

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    replayDone |-> (!replayActive && $past(replayActive))); // R9

  AST_COLLISION_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    writeCollision |=> writeCollision); // R10

  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> outValid); // R1
endmodule

bind pattern_replay pattern_replay_chk #(.BUS_W(NUM_CH*SAMPLE_W)) i_chk (
  .clk            (clk),
  .rstN           (rstN),
  .strobeIn       (strobeIn),
  .liveData       (liveData),
  .outData        (outData),
  .outValid       (outValid),
  .replayActive   (replayActive),
  .replayDone     (replayDone),
  .writeCollision (writeCollision)
);

// File: tb/test_pattern_replay.sv
`timescale 1ns/1ps
module test_pattern_replay;
  localparam int NCH = 4;
  localparam int DEP = 8;
  localparam int SW  = 8;
  localparam int BW  = NCH*SW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [BW-1:0] liveData = '0;
  logic hostWe = 1'b0;
  logic [1:0] hostCh = '0;
  logic [2:0] hostAddr = '0;
  logic [SW-1:0] hostData = '0;
  logic strobeIn = 1'b0;
  logic [BW-1:0] outData;
  logic outValid, replayActive, replayDone, writeCollision;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [SW-1:0] model [NCH][DEP];

  always #10 clk = ~clk;

  pattern_replay #(.NUM_CH(NCH), .DEPTH(DEP), .SAMPLE_W(SW)) i_pattern_replay (
    .clk(clk), .rstN(rstN), .liveData(liveData), .hostWe(hostWe),
    .hostCh(hostCh), .hostAddr(hostAddr), .hostData(hostData),
    .strobeIn(strobeIn), .outData(outData), .outValid(outValid),
    .replayActive(replayActive), .replayDone(replayDone),
    .writeCollision(writeCollision)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [BW-1:0] replayBus(input int idx);
    logic [BW-1:0] b;
    for (int c = 0; c < NCH; c++) b[c*SW +: SW] = model[c][idx];
    return b;
  endfunction

  task automatic hostWrite(input int ch, input int a, input logic [SW-1:0] d, input bit track);
    hostWe = 1'b1; hostCh = 2'(ch); hostAddr = 3'(a); hostData = d;
    @(negedge clk);
    hostWe = 1'b0;
    if (track) model[ch][a] = d;
  endtask

  // Strobe held high for n clock edges; checks every output clock.
  task automatic replay(input int n, input bit collide, input string firstTag, input string idx2Tag);
    logic [BW-1:0] liveConst;
    liveConst = {BW{1'b0}} | 32'h5AC3_9E17;
    liveData = liveConst;
    strobeIn = 1'b1;
    for (int i = 1; i <= n + 4; i++) begin
      @(negedge clk);
      if (i == n) strobeIn = 1'b0;
      if (collide && i == 4) begin
        hostWe = 1'b1; hostCh = 2'd1; hostAddr = 3'd2; hostData = ~model[1][2];
      end
      if (collide && i == 5) hostWe = 1'b0;
      if (i <= 2) begin
        check(outData == liveConst, "R4 live before replay", outData, liveConst);
        check(!replayActive, "R4 active low before replay", replayActive, 0);
      end else if (i <= n + 2) begin
        int k;
        int idx;
        string tag;
        k = i - 3;
        idx = (k < DEP) ? k : DEP - 1;
        tag = (k >= DEP) ? "R6 saturate" : (k == 0) ? firstTag : (idx == 2) ? idx2Tag : "R5 sample";
        check(outData == replayBus(idx), tag, outData, replayBus(idx));
        check(replayActive && !replayDone, "R4 active during replay", replayActive, 1);
        liveData = ~liveData;  // R8: live changes must not show
      end else if (i == n + 3) begin
        check(outData == liveData, "R8 live back after replay", outData, liveData);
        check(replayDone && !replayActive, "R9 done pulse", replayDone, 1);
      end else begin
        check(!replayDone, "R9 done one clock", replayDone, 0);
      end
    end
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && !replayActive && !replayDone && !writeCollision,
          "R1 reset state", {outValid, replayActive, replayDone, writeCollision}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid, "R1 valid after reset", outValid, 1);

    // R2: fill every location, then overwrite with the real pattern
    for (int c = 0; c < NCH; c++)
      for (int a = 0; a < DEP; a++) hostWrite(c, a, 8'hFF, 1'b1);
    for (int c = 0; c < NCH; c++)
      for (int a = 0; a < DEP; a++) hostWrite(c, a, SW'(c*37 + a*11 + 5), 1'b1);

    // R3: live pass-through sweep
    for (int p = 0; p < 16; p++) begin
      logic [BW-1:0] pat;
      pat = BW'(p * 32'h1357_9BDF + 32'h0F1E_2D3C);
      liveData = pat;
      @(negedge clk);
      check(outData == pat && !replayActive, "R3 live pass", outData, pat);
    end

    replay(1, 1'b0, "R5 single sample", "R5 sample");
    replay(3, 1'b0, "R2 stored pattern", "R5 sample");
    replay(DEP, 1'b0, "R5 first sample", "R5 sample");
    replay(DEP + 5, 1'b0, "R5 first sample", "R5 sample");
    replay(4, 1'b0, "R7 restart at zero", "R5 sample");

    check(!writeCollision, "R10 no collision yet", writeCollision, 0);
    replay(6, 1'b1, "R5 first sample", "R10 write ignored");
    check(writeCollision, "R10 collision set", writeCollision, 1);
    replay(4, 1'b0, "R7 restart at zero", "R10 memory unchanged");

    // R2: rewrite channel 2 and replay it
    for (int a = 0; a < DEP; a++) hostWrite(2, a, SW'(200 - a*9), 1'b1);
    replay(DEP, 1'b0, "R2 rewritten pattern", "R2 rewritten pattern");
    check(writeCollision, "R10 collision sticky", writeCollision, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule